// File: doc/BRIEF.md
# Split-Transaction Response Sequence Checker

This block watches one processor's side of a split-transaction system bus. Each time the processor issues a request, the block records the request number and request type. It then checks every data beat and every completion that the outside world returns under that number against the response grammar for that type. A read must see its data beats, with the right data kind, before an acknowledging completion. An upgrade may finish with a completion alone. Writes and eliminates must receive nothing back at all. The same rules hold for each processor whether the system has one processor or many.

The block has no side effect on the bus. It exposes one busy flag per request number. When a transaction retires cleanly it raises a one-cycle done pulse that carries the number and the completion code. When a rule is broken it raises a one-cycle violation pulse with a reason code and the number involved. The final data beat and its completion may come in the same cycle, or the completion may come any number of cycles later. The reset input is asynchronous and active low, and it is expected to be released synchronously to `clk`.

Top module: `split_txn_checker`

## Requirements
- R1: Request types are 0 block read, 1 double-word read, 2 single-word read, 3 partial-word read, 4 block write, 5 word write, 6 upgrade and 7 eliminate. An accepted issue of type 0, 1, 2, 3 or 6 sets `busy[tag]` one cycle later. Types 4, 5 and 7 never set it.
- R2: A block read (type 0) completes when it receives zero or more non-final block beats (`dat_blk`=1, `dat_last`=0), then a final block beat (`dat_last`=1), then a completion with code 0 ACK, 1 NACK or 2 ERR.
- R3: With no data received yet, a read of types 0 to 3 accepts a bare completion only with code NACK or ERR. A bare ACK gives reason 3. An upgrade (type 6) accepts a bare completion with any code.
- R4: Word reads (types 1 to 3) require `dat_blk`=0 on every beat. Block reads and upgrades require `dat_blk`=1. A beat of the wrong kind gives reason 2.
- R5: A completion in the same cycle as the final beat for the same number is accepted, as is a completion any number of cycles after the final beat.
- R6: A data beat or completion addressed to a number whose latest issue was type 4, 5 or 7 gives reason 1 unexpected response.
- R7: A completion after a non-final beat but before the final beat gives reason 3. A data beat after the final beat, or after the transaction has completed, also gives reason 3.
- R8: A data beat to a number never issued since reset gives reason 4 unsolicited. So does a completion to a number that is not busy and was not last issued as type 4, 5 or 7.
- R9: Issuing on a busy number gives reason 5 duplicate issue. The existing record stays unchanged and can still complete normally.
- R10: An accepted completion raises `done_vld` for exactly one cycle, one cycle after the completion input. `done_tag` and `done_code` carry that completion's number and code, and `busy` for that number is low in the same cycle.
- R11: A violation raises `viol_vld` for one cycle, one cycle after the offending input, with `viol_code` and `viol_tag`. When several violations occur in one cycle, the data beat's is reported first, then the completion's, then the issue's. `viol_code` is 0 when `viol_vld` is low. A response violation returns that number to the free, never-issued condition.
- R12: After reset every busy flag is low and no done or violation pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_vld | input | 1 | Processor request issued this cycle |
| iss_tag | input | TAG_W | Request number of the issue |
| iss_type | input | 3 | Request type (R1 encoding) |
| dat_vld | input | 1 | External data response this cycle |
| dat_tag | input | TAG_W | Request number of the data response |
| dat_blk | input | 1 | Data kind: 1 block, 0 word |
| dat_last | input | 1 | Final data response of the transaction |
| cmp_vld | input | 1 | External completion response this cycle |
| cmp_tag | input | TAG_W | Request number of the completion |
| cmp_code | input | 2 | 0 ACK, 1 NACK, 2 ERR |
| busy | output | 2**TAG_W | One flag per request number awaiting responses |
| done_vld | output | 1 | Transaction retired cleanly |
| done_tag | output | TAG_W | Number of the retired transaction |
| done_code | output | 2 | Completion code of the retired transaction |
| viol_vld | output | 1 | Protocol violation detected |
| viol_code | output | 3 | Reason: 1 unexpected, 2 wrong kind, 3 ordering, 4 unsolicited, 5 duplicate |
| viol_tag | output | TAG_W | Number involved in the violation |

## Verification
The bound assertions check the relations that hold on every cycle at the ports. A non-duplicate issue of a response-bearing type sets its busy flag. No busy flag rises without an issue. A duplicate issue and a completion to a free number are always flagged. Every done pulse mirrors the completion of the previous cycle, with its busy flag already clear. Reason codes stay within their range. The grammar itself can only be shown by the bench's scenarios, because it depends on history that the ports do not expose. That grammar covers wrong data kinds, ordering faults after a completion, responses to write-type requests, completion in the same cycle as the final beat, and violation priority. The bench covers these with directed sequences and with a long random run compared against its own model of the rules.

// File: rtl/stc_pkg.sv
package stc_pkg;

  typedef enum logic [2:0] {
    RQ_BLK_RD  = 3'd0,
    RQ_DW_RD   = 3'd1,
    RQ_SW_RD   = 3'd2,
    RQ_PW_RD   = 3'd3,
    RQ_BLK_WR  = 3'd4,
    RQ_WD_WR   = 3'd5,
    RQ_UPGRADE = 3'd6,
    RQ_ELIM    = 3'd7
  } req_kind_e;

  typedef enum logic [2:0] {
    SL_IDLE   = 3'd0,  // never issued or cleared by a violation
    SL_NORESP = 3'd1,  // last issue expects no response
    SL_OPEN   = 3'd2,  // issued, nothing received
    SL_BEAT   = 3'd3,  // non-final data received
    SL_FINAL  = 3'd4,  // final data received, completion pending
    SL_RETIRED = 3'd5  // completed; remembers for late data
  } slot_st_e;

  localparam int RSN_W = 3;
  typedef logic [RSN_W-1:0] rsn_t;

  localparam rsn_t RSN_NONE  = 3'd0;
  localparam rsn_t RSN_UNEXP = 3'd1;
  localparam rsn_t RSN_KIND  = 3'd2;
  localparam rsn_t RSN_ORDER = 3'd3;
  localparam rsn_t RSN_UNSOL = 3'd4;
  localparam rsn_t RSN_DUP   = 3'd5;

  localparam logic [1:0] CMP_ACK  = 2'd0;
  localparam logic [1:0] CMP_NACK = 2'd1;
  localparam logic [1:0] CMP_ERR  = 2'd2;

  function automatic logic kind_no_reply(req_kind_e k);
    return (k == RQ_BLK_WR) || (k == RQ_WD_WR) || (k == RQ_ELIM);
  endfunction

  function automatic logic kind_wants_block(req_kind_e k);
    return (k == RQ_BLK_RD) || (k == RQ_UPGRADE);
  endfunction

endpackage

// File: rtl/stc_tag_slot.sv
module stc_tag_slot
  import stc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       iss_hit,
  input  req_kind_e  iss_type,
  input  logic       dat_hit,
  input  logic       dat_blk,
  input  logic       dat_last,
  input  logic       cmp_hit,
  input  logic [1:0] cmp_code,
  output logic       busy,
  output rsn_t       dat_rsn,
  output rsn_t       cmp_rsn,
  output logic       iss_dup,
  output logic       cmp_ok
);

  slot_st_e st_q, st_a, st_b, st_d;
  logic     blk_q, blk_d;
  logic     upg_q, upg_d;
  logic     upd_en;

  assign busy = (st_q == SL_OPEN) || (st_q == SL_BEAT) || (st_q == SL_FINAL);

  // data stage: evaluated on the state at the start of the cycle
  always_comb begin
    st_a    = st_q;
    dat_rsn = RSN_NONE;
    if (dat_hit) begin
      case (st_q)
        SL_IDLE: dat_rsn = RSN_UNSOL;
        SL_NORESP: begin
          dat_rsn = RSN_UNEXP;
          st_a    = SL_IDLE;
        end
        SL_OPEN, SL_BEAT: begin
          if (dat_blk != blk_q) begin
            dat_rsn = RSN_KIND;
            st_a    = SL_IDLE;
          end else begin
            st_a = dat_last ? SL_FINAL : SL_BEAT;
          end
        end
        default: begin  // SL_FINAL, SL_RETIRED
          dat_rsn = RSN_ORDER;
          st_a    = SL_IDLE;
        end
      endcase
    end
  end

  // completion stage: sees the data stage result (same-cycle final beat)
  always_comb begin
    st_b    = st_a;
    cmp_rsn = RSN_NONE;
    cmp_ok  = 1'b0;
    if (cmp_hit) begin
      case (st_a)
        SL_NORESP: begin
          cmp_rsn = RSN_UNEXP;
          st_b    = SL_IDLE;
        end
        SL_OPEN: begin
          if ((cmp_code == CMP_ACK) && !upg_q) begin
            cmp_rsn = RSN_ORDER;
            st_b    = SL_IDLE;
          end else begin
            cmp_ok = 1'b1;
            st_b   = SL_RETIRED;
          end
        end
        SL_BEAT: begin
          cmp_rsn = RSN_ORDER;
          st_b    = SL_IDLE;
        end
        SL_FINAL: begin
          cmp_ok = 1'b1;
          st_b   = SL_RETIRED;
        end
        default: begin  // SL_IDLE, SL_RETIRED
          cmp_rsn = RSN_UNSOL;
          st_b    = SL_IDLE;
        end
      endcase
    end
  end

  // issue stage: duplicate check on start-of-cycle state, wins the write
  always_comb begin
    st_d    = st_b;
    blk_d   = blk_q;
    upg_d   = upg_q;
    iss_dup = iss_hit && busy;
    if (iss_hit && !busy) begin
      st_d  = kind_no_reply(iss_type) ? SL_NORESP : SL_OPEN;
      blk_d = kind_wants_block(iss_type);
      upg_d = (iss_type == RQ_UPGRADE);
    end
  end

  assign upd_en = iss_hit || dat_hit || cmp_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SL_IDLE;
      blk_q <= 1'b0;
      upg_q <= 1'b0;
    end else if (upd_en) begin
      st_q  <= st_d;
      blk_q <= blk_d;
      upg_q <= upg_d;
    end
  end

endmodule

// File: rtl/stc_report.sv
module stc_report
  import stc_pkg::*;
#(
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rsn_t             dat_rsn,
  input  logic [TAG_W-1:0] dat_tag,
  input  rsn_t             cmp_rsn,
  input  logic             cmp_ok,
  input  logic [TAG_W-1:0] cmp_tag,
  input  logic [1:0]       cmp_code,
  input  logic             iss_dup,
  input  logic [TAG_W-1:0] iss_tag,
  output logic             done_vld,
  output logic [TAG_W-1:0] done_tag,
  output logic [1:0]       done_code,
  output logic             viol_vld,
  output rsn_t             viol_code,
  output logic [TAG_W-1:0] viol_tag
);

  rsn_t             code_d;
  logic [TAG_W-1:0] vtag_d;
  logic [TAG_W-1:0] dtag_d;
  logic [1:0]       dcode_d;

  // fixed priority: data, then completion, then issue
  always_comb begin
    code_d = RSN_NONE;
    vtag_d = '0;
    if (dat_rsn != RSN_NONE) begin
      code_d = dat_rsn;
      vtag_d = dat_tag;
    end else if (cmp_rsn != RSN_NONE) begin
      code_d = cmp_rsn;
      vtag_d = cmp_tag;
    end else if (iss_dup) begin
      code_d = RSN_DUP;
      vtag_d = iss_tag;
    end
  end

  always_comb begin
    dtag_d  = cmp_ok ? cmp_tag  : '0;
    dcode_d = cmp_ok ? cmp_code : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_vld  <= 1'b0;
      done_tag  <= '0;
      done_code <= '0;
      viol_vld  <= 1'b0;
      viol_code <= RSN_NONE;
      viol_tag  <= '0;
    end else begin
      done_vld  <= cmp_ok;
      done_tag  <= dtag_d;
      done_code <= dcode_d;
      viol_vld  <= (code_d != RSN_NONE);
      viol_code <= code_d;
      viol_tag  <= vtag_d;
    end
  end

endmodule

// File: rtl/split_txn_checker.sv
module split_txn_checker
  import stc_pkg::*;
#(
  parameter int  TAG_W    = 3,
  localparam int NUM_TAGS = 1 << TAG_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                iss_vld,
  input  logic [TAG_W-1:0]    iss_tag,
  input  logic [2:0]          iss_type,
  input  logic                dat_vld,
  input  logic [TAG_W-1:0]    dat_tag,
  input  logic                dat_blk,
  input  logic                dat_last,
  input  logic                cmp_vld,
  input  logic [TAG_W-1:0]    cmp_tag,
  input  logic [1:0]          cmp_code,
  output logic [NUM_TAGS-1:0] busy,
  output logic                done_vld,
  output logic [TAG_W-1:0]    done_tag,
  output logic [1:0]          done_code,
  output logic                viol_vld,
  output logic [2:0]          viol_code,
  output logic [TAG_W-1:0]    viol_tag
);

  rsn_t              slot_dat_rsn [NUM_TAGS];
  rsn_t              slot_cmp_rsn [NUM_TAGS];
  logic [NUM_TAGS-1:0] slot_dup;
  logic [NUM_TAGS-1:0] slot_ok;

  rsn_t dat_rsn_any;
  rsn_t cmp_rsn_any;
  rsn_t viol_rsn;

  for (genvar g = 0; g < NUM_TAGS; g++) begin : g_slot
    logic iss_hit, dat_hit, cmp_hit;
    assign iss_hit = iss_vld && (iss_tag == TAG_W'(g));
    assign dat_hit = dat_vld && (dat_tag == TAG_W'(g));
    assign cmp_hit = cmp_vld && (cmp_tag == TAG_W'(g));

    stc_tag_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .iss_hit  (iss_hit),
      .iss_type (req_kind_e'(iss_type)),
      .dat_hit  (dat_hit),
      .dat_blk  (dat_blk),
      .dat_last (dat_last),
      .cmp_hit  (cmp_hit),
      .cmp_code (cmp_code),
      .busy     (busy[g]),
      .dat_rsn  (slot_dat_rsn[g]),
      .cmp_rsn  (slot_cmp_rsn[g]),
      .iss_dup  (slot_dup[g]),
      .cmp_ok   (slot_ok[g])
    );
  end

  // at most one slot is hit per event, so an OR merges the results
  always_comb begin
    dat_rsn_any = RSN_NONE;
    cmp_rsn_any = RSN_NONE;
    for (int i = 0; i < NUM_TAGS; i++) begin
      dat_rsn_any = dat_rsn_any | slot_dat_rsn[i];
      cmp_rsn_any = cmp_rsn_any | slot_cmp_rsn[i];
    end
  end

  stc_report #(.TAG_W(TAG_W)) u_report (
    .clk       (clk),
    .rst_n     (rst_n),
    .dat_rsn   (dat_rsn_any),
    .dat_tag   (dat_tag),
    .cmp_rsn   (cmp_rsn_any),
    .cmp_ok    (|slot_ok),
    .cmp_tag   (cmp_tag),
    .cmp_code  (cmp_code),
    .iss_dup   (|slot_dup),
    .iss_tag   (iss_tag),
    .done_vld  (done_vld),
    .done_tag  (done_tag),
    .done_code (done_code),
    .viol_vld  (viol_vld),
    .viol_code (viol_rsn),
    .viol_tag  (viol_tag)
  );

  assign viol_code = viol_rsn;

endmodule

// File: rtl/stc_checker.sv
module stc_checker #(
  parameter int  TAG_W    = 3,
  localparam int NUM_TAGS = 1 << TAG_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic                iss_vld,
  input logic [TAG_W-1:0]    iss_tag,
  input logic [2:0]          iss_type,
  input logic                dat_vld,
  input logic [TAG_W-1:0]    dat_tag,
  input logic                cmp_vld,
  input logic [TAG_W-1:0]    cmp_tag,
  input logic [1:0]          cmp_code,
  input logic [NUM_TAGS-1:0] busy,
  input logic                done_vld,
  input logic [TAG_W-1:0]    done_tag,
  input logic [1:0]          done_code,
  input logic                viol_vld,
  input logic [2:0]          viol_code
);

  a_r1_issue_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld && !busy[iss_tag] && (iss_type inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd6}))
      |=> busy[$past(iss_tag)]);

  a_r1_busy_needs_issue: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_vld |=> ((busy & ~$past(busy)) == '0));

  a_r9_dup_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld && busy[iss_tag]) |=> viol_vld);

  a_r9_dup_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld && busy[iss_tag] && !(dat_vld && dat_tag == iss_tag)
      && !(cmp_vld && cmp_tag == iss_tag)) |=> busy[$past(iss_tag)]);

  a_r8_cmp_on_free_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_vld && !busy[cmp_tag]) |=> viol_vld);

  a_r10_done_mirrors_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld |-> ($past(cmp_vld) && (done_tag == $past(cmp_tag))
                  && (done_code == $past(cmp_code))));

  a_r10_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld |-> !busy[done_tag]);

  a_r11_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    viol_vld |-> (viol_code inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd5}));

  a_r11_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_vld |-> (viol_code == 3'd0));

endmodule

bind split_txn_checker stc_checker #(.TAG_W(TAG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_vld   (iss_vld),
  .iss_tag   (iss_tag),
  .iss_type  (iss_type),
  .dat_vld   (dat_vld),
  .dat_tag   (dat_tag),
  .cmp_vld   (cmp_vld),
  .cmp_tag   (cmp_tag),
  .cmp_code  (cmp_code),
  .busy      (busy),
  .done_vld  (done_vld),
  .done_tag  (done_tag),
  .done_code (done_code),
  .viol_vld  (viol_vld),
  .viol_code (viol_code)
);

// File: tb/test_split_txn_checker.sv
module test_split_txn_checker;

  localparam int TW = 3;
  localparam int NT = 1 << TW;

  logic          clk;
  logic          rst_n;
  logic          iss_vld;
  logic [TW-1:0] iss_tag;
  logic [2:0]    iss_type;
  logic          dat_vld;
  logic [TW-1:0] dat_tag;
  logic          dat_blk;
  logic          dat_last;
  logic          cmp_vld;
  logic [TW-1:0] cmp_tag;
  logic [1:0]    cmp_code;
  logic [NT-1:0] busy;
  logic          done_vld;
  logic [TW-1:0] done_tag;
  logic [1:0]    done_code;
  logic          viol_vld;
  logic [2:0]    viol_code;
  logic [TW-1:0] viol_tag;

  split_txn_checker #(.TAG_W(TW)) i_split_txn_checker (
    .clk(clk), .rst_n(rst_n),
    .iss_vld(iss_vld), .iss_tag(iss_tag), .iss_type(iss_type),
    .dat_vld(dat_vld), .dat_tag(dat_tag), .dat_blk(dat_blk), .dat_last(dat_last),
    .cmp_vld(cmp_vld), .cmp_tag(cmp_tag), .cmp_code(cmp_code),
    .busy(busy), .done_vld(done_vld), .done_tag(done_tag), .done_code(done_code),
    .viol_vld(viol_vld), .viol_code(viol_code), .viol_tag(viol_tag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;

  // model of the rules: 0 free, 1 no-reply, 2 open, 3 beats, 4 final, 5 retired
  int       ms [NT];
  bit       mk [NT];
  bit       mu [NT];
  logic [NT-1:0] e_busy;
  logic          e_done;
  logic [TW-1:0] e_dtag;
  logic [1:0]    e_dcode;
  logic [2:0]    e_code;
  logic [TW-1:0] e_vtag;

  function automatic bit is_busy(int s);
    return (s >= 2) && (s <= 4);
  endfunction

  task automatic model_step();
    int d = 0;
    int c = 0;
    bit i5 = 0;
    bit ok = 0;
    bit b0 [NT];
    for (int t = 0; t < NT; t++) b0[t] = is_busy(ms[t]);
    if (dat_vld) begin
      int t = int'(dat_tag);
      case (ms[t])
        0: d = 4;
        1: begin d = 1; ms[t] = 0; end
        2, 3: if (dat_blk != mk[t]) begin d = 2; ms[t] = 0; end
              else ms[t] = dat_last ? 4 : 3;
        default: begin d = 3; ms[t] = 0; end
      endcase
    end
    if (cmp_vld) begin
      int t = int'(cmp_tag);
      case (ms[t])
        1: begin c = 1; ms[t] = 0; end
        2: if (cmp_code == 2'd0 && !mu[t]) begin c = 3; ms[t] = 0; end
           else begin ok = 1; ms[t] = 5; end
        3: begin c = 3; ms[t] = 0; end
        4: begin ok = 1; ms[t] = 5; end
        default: begin c = 4; ms[t] = 0; end
      endcase
    end
    if (iss_vld) begin
      int t = int'(iss_tag);
      if (b0[t]) i5 = 1;
      else begin
        ms[t] = (iss_type inside {3'd4, 3'd5, 3'd7}) ? 1 : 2;
        mk[t] = (iss_type == 3'd0) || (iss_type == 3'd6);
        mu[t] = (iss_type == 3'd6);
      end
    end
    e_done  = ok;
    e_dtag  = ok ? cmp_tag : '0;
    e_dcode = ok ? cmp_code : '0;
    if (d != 0)      begin e_code = 3'(d); e_vtag = dat_tag; end
    else if (c != 0) begin e_code = 3'(c); e_vtag = cmp_tag; end
    else if (i5)     begin e_code = 3'd5;  e_vtag = iss_tag; end
    else             begin e_code = 3'd0;  e_vtag = '0; end
    for (int t = 0; t < NT; t++) e_busy[t] = is_busy(ms[t]);
  endtask

  task automatic idle_inputs();
    iss_vld = 0; iss_tag = '0; iss_type = '0;
    dat_vld = 0; dat_tag = '0; dat_blk = 0; dat_last = 0;
    cmp_vld = 0; cmp_tag = '0; cmp_code = '0;
  endtask

  // inputs already set at a falling edge; one clock later compare
  task automatic cyc(string lbl);
    model_step();
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (busy !== e_busy || done_vld !== e_done || done_tag !== e_dtag ||
        done_code !== e_dcode || viol_vld !== (e_code != 0) ||
        viol_code !== e_code || viol_tag !== e_vtag) begin
      errors++;
      $display("FAIL %s: got busy=%b done=%b/%0d/%0d viol=%b/%0d/%0d exp busy=%b done=%b/%0d/%0d viol=%b/%0d/%0d",
               lbl, busy, done_vld, done_tag, done_code, viol_vld, viol_code, viol_tag,
               e_busy, e_done, e_dtag, e_dcode, (e_code != 0), e_code, e_vtag);
    end
    idle_inputs();
  endtask

  task automatic issue(int t, int ty);
    iss_vld = 1; iss_tag = TW'(t); iss_type = 3'(ty);
  endtask
  task automatic beat(int t, bit blk, bit last);
    dat_vld = 1; dat_tag = TW'(t); dat_blk = blk; dat_last = last;
  endtask
  task automatic compl(int t, int code);
    cmp_vld = 1; cmp_tag = TW'(t); cmp_code = 2'(code);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1207));
    for (int t = 0; t < NT; t++) begin ms[t] = 0; mk[t] = 0; mu[t] = 0; end
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R12 reset state
    cyc("R12 reset state");

    // R1 / R2 block read with beats then later ACK
    issue(1, 0);        cyc("R1 block read sets busy");
    beat(1, 1, 0);      cyc("R2 non-final block beat");
    beat(1, 1, 1);      cyc("R2 final block beat");
    compl(1, 0);        cyc("R2 ACK after final beat");
    // R4 / R5 word read, final beat and completion in one cycle
    issue(2, 1);        cyc("R1 word read issue");
    beat(2, 0, 1); compl(2, 0); cyc("R5 same-cycle completion");
    // R4 wrong kind
    issue(3, 2);        cyc("R1 single-word read issue");
    beat(3, 1, 0);      cyc("R4 block beat on word read");
    issue(3, 0);        cyc("R4 block read issue");
    beat(3, 0, 1);      cyc("R4 word beat on block read");
    // R3 bare completions
    issue(4, 0);        cyc("R3 issue");
    compl(4, 1);        cyc("R3 bare NACK on read");
    issue(5, 3);        cyc("R3 issue partial read");
    compl(5, 0);        cyc("R3 bare ACK on read");
    issue(6, 6);        cyc("R3 upgrade issue");
    compl(6, 0);        cyc("R3 bare ACK on upgrade");
    // R6 no-reply types
    issue(7, 4);        cyc("R1 block write leaves busy low");
    beat(7, 1, 1);      cyc("R6 data on block write");
    issue(7, 7);        cyc("R1 eliminate leaves busy low");
    compl(7, 2);        cyc("R6 completion on eliminate");
    // R8 unsolicited
    beat(0, 1, 1);      cyc("R8 data on never-issued number");
    compl(4, 0);        cyc("R8 completion on retired number");
    // R9 duplicate issue
    issue(0, 0);        cyc("R9 first issue");
    issue(0, 1);        cyc("R9 duplicate issue");
    beat(0, 1, 1);      cyc("R9 record kept");
    repeat (3) cyc("R5 wait before completion");
    compl(0, 2);        cyc("R5 late ERR completion");
    // R7 ordering
    issue(2, 0);        cyc("R7 issue");
    beat(2, 1, 0);      cyc("R7 beat");
    compl(2, 1);        cyc("R7 completion before final beat");
    beat(0, 1, 0);      cyc("R7 data after completion");
    issue(1, 6);        cyc("R7 upgrade issue");
    beat(1, 1, 1);      cyc("R7 upgrade final beat");
    beat(1, 1, 0);      cyc("R7 data after final beat");
    // R11 priority: data viol, completion viol and dup issue together
    issue(3, 0);        cyc("R11 setup issue");
    issue(5, 5);        cyc("R11 setup write");
    beat(5, 0, 0); compl(6, 1); issue(3, 2); cyc("R11 priority data first");
    compl(6, 1); issue(3, 2); cyc("R11 priority completion before issue");
    issue(3, 2);        cyc("R11 duplicate alone");

    // random run against the model
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(99) < 40) issue($urandom_range(NT-1), $urandom_range(7));
      if ($urandom_range(99) < 40) beat($urandom_range(NT-1), $urandom_range(99) < 70,
                                        $urandom_range(1));
      if ($urandom_range(99) < 30) compl($urandom_range(NT-1), $urandom_range(2));
      cyc("R11 random mix");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule